// File: doc/BRIEF.md
# Multiplexed-Bus Register Address Decoder

This block sits behind a host bus on which address and data share the same wires. During the address phase it captures the address, and later, when the host asserts a read or write strobe, it turns that captured address into a bank select, a register index and a one-cycle read or write enable. There are two register banks behind it: a serial-controller bank and a DMA bank. The strobe phase never uses the live bus to pick a register.

Some hosts use address bit 0 to steer bytes on a 16-bit bus, so each bank can ignore that bit. In shift-right mode the index comes from bits 4..0 of the captured address. In shift-left mode it comes from bits 5..1. Each bank holds its own shift setting, and the block updates both settings itself by watching writes to two configuration registers. The DMA bank also offers indirect access. A write to its command/address register loads a pointer. The next access that addresses that register then goes to the register the pointer names, and the pointer clears.

The control path is a five-state machine:
- ST_IDLE waits for an address phase.
- ST_ADDR holds a captured address and waits for a strobe.
- ST_RD and ST_WR each last one cycle, and the enable is high during that cycle.
- ST_HOLD waits until both strobes are released.

Transitions:
- latch: a falling address strobe with chip select low moves any state to ST_ADDR.
- abort: chip select high in ST_ADDR moves to ST_IDLE.
- read fire: a low read strobe in ST_ADDR moves to ST_RD. It takes priority over a write.
- write fire: a low write strobe alone in ST_ADDR moves to ST_WR.
- done: ST_RD or ST_WR always moves to ST_HOLD.
- release: in ST_HOLD, both strobes high moves to ST_IDLE.

Top module: `mux_reg_decoder`

## Requirements
- R1: After reset, rd_en and wr_en are 0, both banks are in shift-right mode and the pointer is zero.
- R2: The register index comes only from the address captured on the clock edge where address strobe is first seen low (it was high the cycle before) while chip select is low. Later changes on ad do not alter the index.
- R3: A falling address strobe while chip select is high captures nothing, and no enable follows it.
- R4: In shift-right mode, reg_idx equals captured bits 4..0. In shift-left mode, reg_idx equals captured bits 5..1, and bit 0 is ignored.
- R5: A write to serial bank index 0 sets that bank's mode from data bits 1:0. The value 01 selects shift-left, 10 selects shift-right, and 00 or 11 leave the mode unchanged.
- R6: A write to DMA bank index 1 sets the DMA bank's mode from data bit 0: 1 selects shift-left and 0 selects shift-right. Each bank's mode has no effect on the other bank.
- R7: A write to DMA bank index 0 while the pointer is zero loads the pointer from data bits 4..0, and the access itself reports index 0.
- R8: While the pointer is nonzero, an access that addresses DMA index 0 reports the pointer value as reg_idx and acts on that register. The pointer then returns to zero.
- R9: While the pointer is nonzero, an access to any other DMA index or to the serial bank uses the captured address and leaves the pointer unchanged.
- R10: rd_en or wr_en goes high for exactly one cycle, in the cycle after a strobe is sampled low in ST_ADDR. There is at most one pulse per address phase, and rd_en wins if both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad | input | AD_W | Multiplexed address/data bus |
| as_n | input | 1 | Address strobe, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bank_in | input | 1 | Bank chosen during the address phase (0 serial, 1 DMA) |
| bank_sel | output | 1 | Bank of the current access |
| reg_idx | output | IDX_W | Effective register index of the current access |
| rd_en | output | 1 | One-cycle read enable |
| wr_en | output | 1 | One-cycle write enable |

## Verification
The bench uses the default parameters: AD_W=8, IDX_W=5, the DMA command/address register at index 0 and its configuration register at index 1. With these values an address with bit 5 set and bit 0 set tells the two shift modes apart in a single read. The DMA configuration register can also be used as a pointer target, which reaches the path where an indirect write changes the DMA shift mode.

// File: rtl/mxdec_pkg.sv
package mxdec_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_RD   = 3'd2,
        ST_WR   = 3'd3,
        ST_HOLD = 3'd4
    } dec_state_t;

    typedef enum logic {
        BANK_SER = 1'b0,
        BANK_DMA = 1'b1
    } bank_t;
endpackage

// File: rtl/mxdec_latch.sv
module mxdec_latch #(
    parameter int LAT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LAT_W-1:0] ad_lo,
    input  logic             as_n,
    input  logic             cs_n,
    input  logic             bank_in,
    output logic             hit,
    output logic [LAT_W-1:0] lat_ad,
    output logic             lat_bank
);
    logic as_prev;

    assign hit = as_prev && !as_n && !cs_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            as_prev  <= 1'b1;
            lat_ad   <= '0;
            lat_bank <= 1'b0;
        end else begin
            as_prev <= as_n;
            if (hit) begin
                lat_ad   <= ad_lo;
                lat_bank <= bank_in;
            end
        end
    end

    // R2
    lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(lat_ad));
endmodule

// File: rtl/mxdec_index.sv
module mxdec_index
    import mxdec_pkg::*;
#(
    parameter int IDX_W    = 5,
    parameter int CCAR_IDX = 0
) (
    input  logic [IDX_W:0]   lat_ad,
    input  logic             lat_bank,
    input  logic             ser_left,
    input  logic             dma_left,
    input  logic [IDX_W-1:0] ptr,
    output logic [IDX_W-1:0] eff_idx,
    output logic             direct_ccar,
    output logic             indirect
);
    logic             left;
    logic [IDX_W-1:0] raw_idx;
    logic             sel_ccar;

    always_comb begin
        left     = (lat_bank == BANK_DMA) ? dma_left : ser_left;
        raw_idx  = left ? lat_ad[IDX_W:1] : lat_ad[IDX_W-1:0];
        sel_ccar = (lat_bank == BANK_DMA) && (raw_idx == IDX_W'(CCAR_IDX));
        indirect    = sel_ccar && (ptr != '0);
        direct_ccar = sel_ccar && (ptr == '0);
        eff_idx     = indirect ? ptr : raw_idx;
    end
endmodule

// File: rtl/mxdec_modes.sv
module mxdec_modes
    import mxdec_pkg::*;
#(
    parameter int IDX_W    = 5,
    parameter int CMD0_IDX = 0,
    parameter int BCR_IDX  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_fire,
    input  logic             wr_fire,
    input  logic             bank,
    input  logic [IDX_W-1:0] eff_idx,
    input  logic             direct_ccar,
    input  logic             indirect,
    input  logic [IDX_W-1:0] wdata,
    output logic             ser_left,
    output logic             dma_left,
    output logic [IDX_W-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_left <= 1'b0;
            dma_left <= 1'b0;
            ptr      <= '0;
        end else begin
            if ((rd_fire || wr_fire) && indirect) begin
                ptr <= '0;
            end else if (wr_fire && direct_ccar) begin
                ptr <= wdata;
            end
            if (wr_fire && bank == BANK_SER && eff_idx == IDX_W'(CMD0_IDX)) begin
                unique case (wdata[1:0])
                    2'b01:   ser_left <= 1'b1;
                    2'b10:   ser_left <= 1'b0;
                    default: ser_left <= ser_left;
                endcase
            end
            if (wr_fire && bank == BANK_DMA && eff_idx == IDX_W'(BCR_IDX)) begin
                dma_left <= wdata[0];
            end
        end
    end

    // R8
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_fire || wr_fire) && indirect) |=> (ptr == '0));
    // R9
    ptr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_fire && !indirect) |=> $stable(ptr));
endmodule

// File: rtl/mux_reg_decoder.sv
module mux_reg_decoder
    import mxdec_pkg::*;
#(
    parameter int AD_W     = 8,
    parameter int IDX_W    = 5,
    parameter int CMD0_IDX = 0,
    parameter int CCAR_IDX = 0,
    parameter int BCR_IDX  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad,
    input  logic             as_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             bank_in,
    output logic             bank_sel,
    output logic [IDX_W-1:0] reg_idx,
    output logic             rd_en,
    output logic             wr_en
);
    localparam int LAT_W = IDX_W + 1;

    dec_state_t       state, state_nx;
    logic             hit;
    logic [LAT_W-1:0] lat_ad;
    logic             lat_bank;
    logic             ser_left, dma_left;
    logic [IDX_W-1:0] ptr, eff_idx;
    logic             direct_ccar, indirect;
    logic             rd_fire, wr_fire;
    logic [IDX_W-1:0] idx_q;
    logic             bank_q;

    mxdec_latch #(.LAT_W(LAT_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .ad_lo(ad[LAT_W-1:0]), .as_n(as_n),
        .cs_n(cs_n), .bank_in(bank_in), .hit(hit), .lat_ad(lat_ad),
        .lat_bank(lat_bank)
    );

    mxdec_index #(.IDX_W(IDX_W), .CCAR_IDX(CCAR_IDX)) u_index (
        .lat_ad(lat_ad), .lat_bank(lat_bank), .ser_left(ser_left),
        .dma_left(dma_left), .ptr(ptr), .eff_idx(eff_idx),
        .direct_ccar(direct_ccar), .indirect(indirect)
    );

    mxdec_modes #(.IDX_W(IDX_W), .CMD0_IDX(CMD0_IDX), .BCR_IDX(BCR_IDX)) u_modes (
        .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .wr_fire(wr_fire),
        .bank(lat_bank), .eff_idx(eff_idx), .direct_ccar(direct_ccar),
        .indirect(indirect), .wdata(ad[IDX_W-1:0]), .ser_left(ser_left),
        .dma_left(dma_left), .ptr(ptr)
    );

    assign rd_fire = (state == ST_ADDR) && !hit && !cs_n && !rd_n;
    assign wr_fire = (state == ST_ADDR) && !hit && !cs_n && rd_n && !wr_n;

    always_comb begin
        state_nx = state;
        if (hit) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_ADDR: begin
                    if (cs_n)       state_nx = ST_IDLE;
                    else if (!rd_n) state_nx = ST_RD;
                    else if (!wr_n) state_nx = ST_WR;
                end
                ST_RD, ST_WR: state_nx = ST_HOLD;
                ST_HOLD: if (rd_n && wr_n) state_nx = ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            bank_q <= 1'b0;
        end else if (rd_fire || wr_fire) begin
            idx_q  <= eff_idx;
            bank_q <= lat_bank;
        end
    end

    always_comb begin
        rd_en    = (state == ST_RD);
        wr_en    = (state == ST_WR);
        reg_idx  = idx_q;
        bank_sel = bank_q;
    end

    // R10
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));
    // R10
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);
    // R10
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    // R3
    no_cs_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !hit) |=> !(rd_en || wr_en));
endmodule

// File: tb/sim_mux_reg_decoder.sv
module sim_mux_reg_decoder;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ad = '0;
    logic       as_n = 1'b1, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, bank_in = 1'b0;
    logic       bank_sel, rd_en, wr_en;
    logic [4:0] reg_idx;
    int         checks = 0, errors = 0;
    bit         done = 0;

    always #(CLK_P/2) clk = ~clk;

    mux_reg_decoder u0 (
        .clk(clk), .rst_n(rst_n), .ad(ad), .as_n(as_n), .cs_n(cs_n),
        .rd_n(rd_n), .wr_n(wr_n), .bank_in(bank_in), .bank_sel(bank_sel),
        .reg_idx(reg_idx), .rd_en(rd_en), .wr_en(wr_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one multiplexed access; ad carries data during the strobe phase
    task automatic access(input bit bnk, input logic [7:0] addr, input logic [7:0] data,
                          input bit rd, input bit wr, input bit cs_ok,
                          input int exp_idx, input string req);
        @(negedge clk);
        cs_n = !cs_ok; bank_in = bnk; ad = addr; as_n = 1'b1;
        @(negedge clk);
        as_n = 1'b0;
        @(negedge clk);
        ad = data; rd_n = !rd; wr_n = !wr;
        @(negedge clk);
        chk({req, " rd_en"}, rd_en, int'(cs_ok && rd));
        chk({req, " wr_en"}, wr_en, int'(cs_ok && wr && !rd));
        if (cs_ok && (rd || wr)) begin
            chk({req, " reg_idx"}, reg_idx, exp_idx);
            chk({req, " bank_sel"}, bank_sel, bnk);
        end
        @(negedge clk);
        chk({req, " pulse end"}, int'(rd_en || wr_en), 0);
        @(negedge clk);
        chk({req, " held strobe"}, int'(rd_en || wr_en), 0);
        rd_n = 1'b1; wr_n = 1'b1; as_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 rd_en reset", rd_en, 0);
        chk("R1 wr_en reset", wr_en, 0);
        access(0, 8'h1F, 8'hFF, 1, 0, 1, 31, "R1 serial default right");
        access(1, 8'h1F, 8'hFF, 1, 0, 1, 31, "R1 dma default right");
    endtask

    task automatic t_shift_serial();
        access(0, 8'h2A, 8'h55, 1, 0, 1, 10, "R4 right drops bit5");
        access(0, 8'h00, 8'h01, 0, 1, 1, 0, "R5 write mode 01");
        access(0, 8'h2B, 8'h00, 1, 0, 1, 21, "R4 serial left");
        access(1, 8'h2B, 8'h00, 1, 0, 1, 11, "R6 dma unaffected");
        access(0, 8'h01, 8'h00, 0, 1, 1, 0, "R5 write mode 00");
        access(0, 8'h2B, 8'h00, 1, 0, 1, 21, "R5 00 keeps left");
        access(0, 8'h01, 8'h03, 0, 1, 1, 0, "R5 write mode 11");
        access(0, 8'h2B, 8'h00, 1, 0, 1, 21, "R5 11 keeps left");
        access(0, 8'h01, 8'h02, 0, 1, 1, 0, "R5 write mode 10");
        access(0, 8'h2B, 8'h00, 1, 0, 1, 11, "R5 back to right");
    endtask

    task automatic t_shift_dma();
        access(1, 8'h01, 8'h01, 0, 1, 1, 1, "R6 dma left write");
        access(1, 8'h07, 8'h00, 1, 0, 1, 3, "R6 dma left read");
        access(0, 8'h07, 8'h00, 1, 0, 1, 7, "R6 serial stays right");
    endtask

    task automatic t_pointer();
        access(1, 8'h01, 8'h07, 0, 1, 1, 0, "R7 load pointer");
        access(1, 8'h05, 8'h00, 1, 0, 1, 2, "R9 other dma index");
        access(0, 8'h00, 8'h00, 1, 0, 1, 0, "R9 serial index 0");
        access(1, 8'h00, 8'h00, 1, 0, 1, 7, "R8 indirect read");
        access(1, 8'h00, 8'h00, 1, 0, 1, 0, "R8 pointer cleared");
        access(1, 8'h00, 8'h01, 0, 1, 1, 0, "R7 load pointer 1");
        access(1, 8'h00, 8'h00, 0, 1, 1, 1, "R8 indirect write cfg");
        access(1, 8'h06, 8'h00, 1, 0, 1, 6, "R8 indirect set right");
    endtask

    task automatic t_bus_rules();
        access(0, 8'h09, 8'h1C, 1, 0, 1, 9, "R2 live bus ignored");
        access(0, 8'h04, 8'h00, 1, 1, 0, 0, "R3 cs high no latch");
        access(0, 8'h0C, 8'h00, 1, 1, 1, 12, "R10 read priority");
        access(1, 8'h03, 8'h00, 0, 0, 1, 0, "R10 no strobe");
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_shift_serial();
        t_shift_dma();
        t_pointer();
        t_bus_rules();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule